// File: doc/BRIEF.md
# Trace Packet Countdown Unit

This unit counts packets as they are written into an on-chip trace buffer. Software loads a start value, enables counting and chooses what happens when the count runs out: nothing, a normal interrupt or a non-maskable interrupt. Each packet strobe seen while counting is enabled takes one off the count. The step from 1 to 0 is the expiry event. After expiry the count stays at zero, and the chosen interrupt stays pending, until software issues a reload command. That command restarts the count from the stored start value and clears the pending interrupt. The same control word also carries two gate bits. Each one switches off one trace path into the trace port: the instruction-trace source or the instrumentation source.

Access goes through a single-cycle register port. A write is taken on the clock edge while `reg_wr` is high. Read data is combinational from `reg_addr`. The register offsets are 0x0 for control, 0x4 for reload value and 0x8 for status.

The design uses two state machines:
- **Counter machine.** Its states are `CNT_EMPTY` (count is zero) and `CNT_ACTIVE` (count is above zero). Its transitions are:
  - *load*: a reload command moves it to `CNT_ACTIVE`, or to `CNT_EMPTY` if the reload value is zero. This can happen from either state.
  - *step*: an enabled strobe in `CNT_ACTIVE` with a count above 1 stays in `CNT_ACTIVE`.
  - *expire*: an enabled strobe in `CNT_ACTIVE` with a count of 1 moves to `CNT_EMPTY`.
  - *hold*: in `CNT_EMPTY`, strobes are ignored.
- **Pending machine.** Its states are `PEND_NONE`, `PEND_IRQ` and `PEND_NMI`. Its transitions are:
  - *raise-irq*: expiry with response 01b, from `PEND_NONE` to `PEND_IRQ`.
  - *raise-nmi*: expiry with response 10b, from `PEND_NONE` to `PEND_NMI`.
  - *clear*: a reload command returns any state to `PEND_NONE`.

Top module: `trace_pkt_counter`

## Requirements
- R1: After reset, control, reload and status all read 0, `irq_o` and `nmi_o` are low, and both trace enables are high.
- R2: The control register at 0x0 holds these bits: count enable at bit 0, response type at bits 2:1, reload command at bit 3, instruction-path disable at bit 4 and instrumentation-path disable at bit 5. Bits 31:6 read 0 and ignore writes. Bit 3 always reads 0. Writing all ones therefore reads back 0x37.
- R3: The reload register at 0x4 keeps the low 11 bits of a write. Its bits 31:11 read 0, so writing all ones reads back 0x7FF.
- R4: Each packet strobe takes one off the count while the enable bit is 1. Strobes while the enable bit is 0 change nothing.
- R5: With response 01b, expiry raises `irq_o` and status bit 1 from the edge on which the count reaches 0.
- R6: With response 10b, expiry raises `nmi_o` and status bit 2 from the edge on which the count reaches 0.
- R7: With response 00b or 11b, expiry leaves `irq_o`, `nmi_o` and the status register unchanged.
- R8: Writing control with bit 3 set loads the count from the reload register and clears a pending interrupt, both on that write's edge.
- R9: After expiry the count holds at 0. Further strobes cause no new expiry, even after the response type is changed.
- R10: A reload command and a packet strobe on the same edge load the full reload value, and the strobe is not counted.
- R11: `insn_trace_en` is the inverse of control bit 4, and `sw_trace_en` is the inverse of control bit 5.
- R12: The status register at 0x8 has the IRQ flag at bit 1 and the NMI flag at bit 2. All its other bits read 0. Writes to it are ignored, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pkt_strobe | input | 1 | One-cycle pulse per trace packet stored |
| irq_o | output | 1 | Normal interrupt level |
| nmi_o | output | 1 | Non-maskable interrupt level |
| insn_trace_en | output | 1 | Enable for the instruction-trace path |
| sw_trace_en | output | 1 | Enable for the instrumentation-trace path |

## Verification
Every state change of this block appears on the first clock edge after its cause. A register write, a reload command or the final enabled strobe shows up in `reg_rdata`, `irq_o`, `nmi_o` and the trace enables one cycle after the inputs were driven. The driver changes inputs only on falling edges and releases them on the next falling edge. It then queues the expected values at that point, and the monitor compares them one time unit later. That comparison falls after the register update and well before the next rising edge. Reads are combinational, so each queued read holds its address for that sampling window only.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    localparam int unsigned OFS_CTRL   = 0;
    localparam int unsigned OFS_RELOAD = 4;
    localparam int unsigned OFS_STATUS = 8;

    localparam int unsigned CB_EN       = 0;
    localparam int unsigned CB_RESP_LO  = 1;
    localparam int unsigned CB_RESP_HI  = 2;
    localparam int unsigned CB_RELOAD   = 3;
    localparam int unsigned CB_INSN_DIS = 4;
    localparam int unsigned CB_SW_DIS   = 5;

    typedef enum logic [1:0] {
        RESP_NONE = 2'b00,
        RESP_IRQ  = 2'b01,
        RESP_NMI  = 2'b10,
        RESP_RSVD = 2'b11
    } resp_e;

    typedef struct packed {
        logic  sw_dis;
        logic  insn_dis;
        resp_e resp;
        logic  cnt_en;
    } ctrl_t;

    typedef enum logic {
        CNT_EMPTY  = 1'b0,
        CNT_ACTIVE = 1'b1
    } cnt_state_e;

    typedef enum logic [1:0] {
        PEND_NONE = 2'b00,
        PEND_IRQ  = 2'b01,
        PEND_NMI  = 2'b10
    } pend_state_e;

endpackage

// File: rtl/tpc_regs.sv
module tpc_regs
    import tpc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              irq_pend,
    input  logic              nmi_pend,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload_val,
    output logic              reload_req
);

    localparam int CTRL_BITS = CB_SW_DIS + 1;

    logic sel_ctrl;
    logic sel_reload;
    logic sel_status;
    logic unused_wbits;

    assign sel_ctrl   = (reg_addr == ADDR_W'(OFS_CTRL));
    assign sel_reload = (reg_addr == ADDR_W'(OFS_RELOAD));
    assign sel_status = (reg_addr == ADDR_W'(OFS_STATUS));

    assign unused_wbits = ^{reg_wdata[DATA_W-1:CNT_W], sel_status};

    assign reload_req = reg_wr && sel_ctrl && reg_wdata[CB_RELOAD];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (reg_wr && sel_ctrl) begin
            ctrl.cnt_en   <= reg_wdata[CB_EN];
            ctrl.resp     <= resp_e'(reg_wdata[CB_RESP_HI:CB_RESP_LO]);
            ctrl.insn_dis <= reg_wdata[CB_INSN_DIS];
            ctrl.sw_dis   <= reg_wdata[CB_SW_DIS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_val <= '0;
        end else if (reg_wr && sel_reload) begin
            reload_val <= reg_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (sel_ctrl) begin
            reg_rdata[CTRL_BITS-1:0] = {ctrl.sw_dis, ctrl.insn_dis, 1'b0,
                                        ctrl.resp, ctrl.cnt_en};
        end else if (sel_reload) begin
            reg_rdata[CNT_W-1:0] = reload_val;
        end else if (sel_status) begin
            reg_rdata[2:0] = {nmi_pend, irq_pend, 1'b0};
        end
    end

    // R2: a control write lands in the stored fields on the next edge
    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel_ctrl) |=> (ctrl.resp == resp_e'($past(reg_wdata[CB_RESP_HI:CB_RESP_LO]))
                                  && ctrl.cnt_en == $past(reg_wdata[CB_EN])));

    // R3: the reload register keeps exactly the low bits
    p_reload_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel_reload) |=> (reload_val == $past(reg_wdata[CNT_W-1:0])));

    // R12: status has no writable state
    p_status_ro_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel_status) |=> ($stable(ctrl) && $stable(reload_val)));

endmodule

// File: rtl/tpc_count_fsm.sv
module tpc_count_fsm
    import tpc_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             strobe,
    input  logic             reload_req,
    input  logic [CNT_W-1:0] reload_val,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_EMPTY;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    always_comb begin
        state_d = state_q;
        count_d = count_q;
        expire  = 1'b0;
        if (reload_req) begin
            count_d = reload_val;
            state_d = (reload_val == '0) ? CNT_EMPTY : CNT_ACTIVE;
        end else begin
            unique case (state_q)
                CNT_EMPTY: begin
                    count_d = '0;
                end
                CNT_ACTIVE: begin
                    if (cnt_en && strobe) begin
                        if (count_q == ONE) begin
                            expire  = 1'b1;
                            count_d = '0;
                            state_d = CNT_EMPTY;
                        end else begin
                            count_d = count_q - ONE;
                        end
                    end
                end
            endcase
        end
    end

    // R4: an enabled strobe above one takes exactly one off
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_ACTIVE && cnt_en && strobe && !reload_req && count_q > ONE)
        |=> (count_q == $past(count_q) - ONE));

    // R4: nothing moves without enable or reload
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !reload_req) |=> $stable(count_q));

    // R9: expiry empties the counter and it stays empty
    p_expire_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (state_q == CNT_EMPTY && count_q == '0));

    p_empty_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_EMPTY && !reload_req) |=> (state_q == CNT_EMPTY && !expire));

    // R10: a reload loads the full value regardless of a strobe
    p_reload_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reload_req |=> (count_q == $past(reload_val)));

endmodule

// File: rtl/tpc_pend_fsm.sv
module tpc_pend_fsm
    import tpc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  expire,
    input  resp_e resp,
    input  logic  reload_req,
    output logic  irq_o,
    output logic  nmi_o
);

    pend_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PEND_NONE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (reload_req) begin
            state_d = PEND_NONE;
        end else if (expire && state_q == PEND_NONE) begin
            unique case (resp)
                RESP_IRQ:  state_d = PEND_IRQ;
                RESP_NMI:  state_d = PEND_NMI;
                RESP_NONE: state_d = PEND_NONE;
                RESP_RSVD: state_d = PEND_NONE;
            endcase
        end
    end

    always_comb begin
        irq_o = 1'b0;
        nmi_o = 1'b0;
        unique case (state_q)
            PEND_NONE: ;
            PEND_IRQ:  irq_o = 1'b1;
            PEND_NMI:  nmi_o = 1'b1;
            default:   ;
        endcase
    end

    p_irq_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && resp == RESP_IRQ && !reload_req) |=> irq_o);

    p_nmi_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && resp == RESP_NMI && !reload_req) |=> nmi_o);

    p_no_action_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && state_q == PEND_NONE && (resp == RESP_NONE || resp == RESP_RSVD))
        |=> (!irq_o && !nmi_o));

    p_reload_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reload_req |=> (!irq_o && !nmi_o));

    p_one_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_o, nmi_o}));

endmodule

// File: rtl/trace_pkt_counter.sv
module trace_pkt_counter
    import tpc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              pkt_strobe,
    output logic              irq_o,
    output logic              nmi_o,
    output logic              insn_trace_en,
    output logic              sw_trace_en
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload_val;
    logic             reload_req;
    logic             expire;

    tpc_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_pend   (irq_o),
        .nmi_pend   (nmi_o),
        .ctrl       (ctrl),
        .reload_val (reload_val),
        .reload_req (reload_req)
    );

    tpc_count_fsm #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (ctrl.cnt_en),
        .strobe     (pkt_strobe),
        .reload_req (reload_req),
        .reload_val (reload_val),
        .expire     (expire)
    );

    tpc_pend_fsm u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire     (expire),
        .resp       (ctrl.resp),
        .reload_req (reload_req),
        .irq_o      (irq_o),
        .nmi_o      (nmi_o)
    );

    assign insn_trace_en = ~ctrl.insn_dis;
    assign sw_trace_en   = ~ctrl.sw_dis;

    // R11: gate outputs follow the last control write, inverted
    p_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFS_CTRL))
        |=> (insn_trace_en == !$past(reg_wdata[CB_INSN_DIS])
             && sw_trace_en == !$past(reg_wdata[CB_SW_DIS])));

endmodule

// File: tb/tb_trace_pkt_counter.sv
`timescale 1ns/1ps
module tb_trace_pkt_counter;

    localparam int SEL_RD   = 0;
    localparam int SEL_IRQ  = 1;
    localparam int SEL_NMI  = 2;
    localparam int SEL_INSN = 3;
    localparam int SEL_SW   = 4;

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pkt_strobe = 1'b0;
    logic        irq_o, nmi_o, insn_trace_en, sw_trace_en;

    item_t q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    always #4 clk = ~clk;

    trace_pkt_counter dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .pkt_strobe    (pkt_strobe),
        .irq_o         (irq_o),
        .nmi_o         (nmi_o),
        .insn_trace_en (insn_trace_en),
        .sw_trace_en   (sw_trace_en)
    );

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic stb = 1'b0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; pkt_strobe = stb;
        @(negedge clk);
        reg_wr = 1'b0; pkt_strobe = 1'b0;
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pkt_strobe = 1'b1;
            @(negedge clk);
            pkt_strobe = 1'b0;
        end
    endtask

    task automatic chk_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        reg_addr = a;
        it.sel = SEL_RD; it.exp = e; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic chk_pin(input int s, input logic e, input string tag);
        item_t it;
        it.sel = s; it.exp = {31'b0, e}; it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: compares one time unit after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.sel)
                    SEL_RD:   act = reg_rdata;
                    SEL_IRQ:  act = {31'b0, irq_o};
                    SEL_NMI:  act = {31'b0, nmi_o};
                    SEL_INSN: act = {31'b0, insn_trace_en};
                    default:  act = {31'b0, sw_trace_en};
                endcase
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_rd(4'h0, 32'h0, "R1 ctrl");
        chk_rd(4'h4, 32'h0, "R1 reload");
        chk_rd(4'h8, 32'h0, "R1 status");
        chk_pin(SEL_IRQ, 1'b0, "R1 irq");
        chk_pin(SEL_NMI, 1'b0, "R1 nmi");
        chk_pin(SEL_INSN, 1'b1, "R1 insn_en");
        chk_pin(SEL_SW, 1'b1, "R1 sw_en");

        // R2 R11 layout, reserved bits, gates
        wr(4'h0, 32'hFFFF_FFFF);
        chk_pin(SEL_INSN, 1'b0, "R11 insn off");
        chk_pin(SEL_SW, 1'b0, "R11 sw off");
        chk_rd(4'h0, 32'h0000_0037, "R2 ctrl all ones");
        wr(4'h0, 32'h10);
        chk_pin(SEL_INSN, 1'b0, "R11 insn bit4");
        chk_pin(SEL_SW, 1'b1, "R11 sw bit4");
        wr(4'h0, 32'h20);
        chk_pin(SEL_INSN, 1'b1, "R11 insn bit5");
        chk_pin(SEL_SW, 1'b0, "R11 sw bit5");

        // R3 reload width
        wr(4'h4, 32'hFFFF_FFFF);
        chk_rd(4'h4, 32'h0000_07FF, "R3 reload width");
        chk_rd(4'hC, 32'h0, "R12 unmapped");

        // R5 irq on expiry
        wr(4'h4, 32'd3);
        wr(4'h0, 32'h0B);
        strobe(2);
        chk_pin(SEL_IRQ, 1'b0, "R5 before expiry");
        strobe(1);
        chk_pin(SEL_IRQ, 1'b1, "R5 irq raised");
        chk_pin(SEL_NMI, 1'b0, "R5 nmi quiet");
        chk_rd(4'h8, 32'h2, "R5 status");
        // R12 status write ignored
        wr(4'h8, 32'hFFFF_FFFF);
        chk_rd(4'h8, 32'h2, "R12 status write ignored");

        // R8 reload clears and restarts
        wr(4'h0, 32'h0B);
        chk_pin(SEL_IRQ, 1'b0, "R8 irq cleared");
        chk_rd(4'h8, 32'h0, "R8 status cleared");
        chk_rd(4'h0, 32'h3, "R2 reload bit reads 0");
        strobe(3);
        chk_pin(SEL_IRQ, 1'b1, "R8 restart expiry");

        // R4 enable gates counting
        wr(4'h0, 32'h0A);
        chk_pin(SEL_IRQ, 1'b0, "R4 cleared");
        strobe(5);
        chk_pin(SEL_IRQ, 1'b0, "R4 disabled strobes");
        wr(4'h0, 32'h03);
        strobe(2);
        chk_pin(SEL_IRQ, 1'b0, "R4 two enabled");
        strobe(1);
        chk_pin(SEL_IRQ, 1'b1, "R4 third expires");

        // R6 nmi
        wr(4'h4, 32'd2);
        wr(4'h0, 32'h0D);
        strobe(2);
        chk_pin(SEL_NMI, 1'b1, "R6 nmi raised");
        chk_pin(SEL_IRQ, 1'b0, "R6 irq quiet");
        chk_rd(4'h8, 32'h4, "R6 status");
        wr(4'h0, 32'h0D);
        chk_pin(SEL_NMI, 1'b0, "R8 nmi cleared");

        // R7 R9 no action, hold at zero
        wr(4'h0, 32'h09);
        strobe(2);
        chk_pin(SEL_IRQ, 1'b0, "R7 resp00 irq");
        chk_pin(SEL_NMI, 1'b0, "R7 resp00 nmi");
        chk_rd(4'h8, 32'h0, "R7 resp00 status");
        wr(4'h0, 32'h03);
        strobe(3);
        chk_pin(SEL_IRQ, 1'b0, "R9 held at zero");
        wr(4'h0, 32'h0F);
        strobe(2);
        chk_pin(SEL_IRQ, 1'b0, "R7 resp11 irq");
        chk_pin(SEL_NMI, 1'b0, "R7 resp11 nmi");

        // R10 reload beats a same-cycle strobe
        wr(4'h0, 32'h0B, 1'b1);
        strobe(1);
        chk_pin(SEL_IRQ, 1'b0, "R10 one left");
        strobe(1);
        chk_pin(SEL_IRQ, 1'b1, "R10 expiry after full count");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule